// File: doc/BRIEF.md
# Denied Access Logger and Counter

This block keeps the diagnostics that an address range filter produces when it refuses a request. The filter presents each refusal as a one-cycle event. The event carries the index of the range that decided it, a flag for the case where no range matched, and the kind of access. It also carries the requester's role, the two role-policy denial flags, the deciding range's own logging flag and the full request address. The block counts the refusals it is allowed to log in a saturating counter. It compares that count with a programmable threshold to drive an interrupt line. It records the details of only the first refusal until software clears the record.

Software sees three words. The config word holds the logging enable, a clear strobe and the threshold. The status word holds the count together with the first refusal's details. The address word holds the first refused address. Software clears the count and the record in one of two ways: it writes the clear strobe, or it pulses the interrupt acknowledge. Every output is registered, so a result becomes visible on the clock edge that samples its stimulus.

Top module: `dlog_top`

## Requirements
- R1: After reset the config, status and address words are all zero and the interrupt is low.
- R2: A config write loads the logging enable from bit 0 and the threshold from bits 9:2. Bit 1 is a clear strobe that is never stored. The config word reads back the enable in bit 0, zero in bit 1 and the threshold in bits 9:2.
- R3: An event counts only when the logging enable and the event's per-range log flag are both set. A counted event raises the count by exactly one, whatever its access type. An event that does not count changes no output.
- R4: The count stops rising once it is nonzero and at or above the threshold, and it also stops at 255. With a threshold of zero the first counted event takes the count to 1, and the count then holds.
- R5: The interrupt is high exactly while the count is nonzero and at or above the threshold. It therefore stays low at count zero, even with a threshold of zero.
- R6: Only a counted event that arrives while the count is zero is recorded, and later events leave the record untouched. The status word places the record as follows. The count sits in bits 7:0. The access-type flags sit in bit 8 (read, type code 0), bit 9 (write, code 1) and bit 10 (execute, code 2); type code 3 sets none of them. Bit 11 holds the no-match flag. Bits 12 and 13 hold the role-policy read and write denial flags. Bits 17:14 hold the 4-bit role and bits 22:18 the 5-bit range index. Bits 31:23 read zero.
- R7: The address word holds the full 32-bit address of the recorded event.
- R8: A config write with bit 1 set clears the count, the status record and the address word. The clear wins over an event in the same cycle, which is then lost. The config fields of that write still load.
- R9: An interrupt acknowledge pulse clears the count, the status record and the address word, and it too wins over a same-cycle event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config word write strobe |
| cfg_wdata_i | input | 10 | Config write data: enable, clear strobe, threshold |
| evt_valid_i | input | 1 | One-cycle denial event |
| evt_idx_i | input | 5 | Index of the deciding range |
| evt_no_match_i | input | 1 | No range matched the request |
| evt_type_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 none |
| evt_role_i | input | 4 | Source role of the request |
| evt_role_rd_deny_i | input | 1 | Role policy refused a read |
| evt_role_wr_deny_i | input | 1 | Role policy refused a write |
| evt_log_en_i | input | 1 | Deciding range allows logging |
| evt_addr_i | input | 32 | Request address |
| intr_ack_i | input | 1 | Interrupt acknowledge pulse |
| cfg_o | output | 32 | Config word readback |
| status_o | output | 32 | Status word: count and first-denial record |
| addr_o | output | 32 | Address of the first recorded denial |
| intr_o | output | 1 | Threshold interrupt |

## Verification
Every stimulus, whether a config write, an event, a clear or an acknowledge, is applied for one cycle. It is sampled on one rising edge, and the count, the record, the address word, the config readback and the interrupt all take their new values on that same edge. The driver applies each stimulus at a falling edge and computes the expected words from the requirements. It queues those words, and the monitor compares them just after the following rising edge, so no result is read early or late. The sequence covers the boundary cases: the same-cycle clear-versus-event race, threshold zero, saturation at 255, and events that must leave the outputs unchanged.

// File: rtl/dlog_pkg.sv
package dlog_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_NONE  = 2'd3
   } acc_type_e;

   localparam int unsigned NumAccTypes = 3;
endpackage

// File: rtl/dlog_cfg_reg.sv
module dlog_cfg_reg #(
   parameter int unsigned CntW = 8,
   localparam int unsigned CfgW = CntW + 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            we_i,
   input  logic [CfgW-1:0] wdata_i,
   output logic            en_o,
   output logic [CntW-1:0] thr_o,
   output logic            clr_o
);
   logic            en_q;
   logic [CntW-1:0] thr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= 1'b0;
         thr_q <= '0;
      end else if (we_i) begin
         en_q  <= wdata_i[0];
         thr_q <= wdata_i[CfgW-1:2];
      end
   end

   assign en_o  = en_q;
   assign thr_o = thr_q;
   assign clr_o = we_i & wdata_i[1];

   // R2
   cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (thr_q == $past(wdata_i[CfgW-1:2])) && (en_q == $past(wdata_i[0])));
endmodule

// File: rtl/dlog_counter.sv
module dlog_counter #(
   parameter int unsigned CntW = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            inc_i,
   input  logic            clr_i,
   input  logic [CntW-1:0] thr_i,
   output logic [CntW-1:0] cnt_o,
   output logic            empty_o,
   output logic            irq_o
);
   localparam logic [CntW-1:0] CntMax = '1;

   logic [CntW-1:0] cnt_q;
   logic            nonzero;
   logic            at_thr;
   logic            at_limit;
   logic            bump;

   assign nonzero  = (cnt_q != '0);
   assign at_thr   = nonzero && (cnt_q >= thr_i);
   assign at_limit = at_thr || (cnt_q == CntMax);
   assign bump     = inc_i && !at_limit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (bump) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o   = cnt_q;
   assign empty_o = !nonzero;
   assign irq_o   = at_thr;

   // R3
   inc_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !clr_i && (cnt_q < thr_i)) |=> (cnt_q == CntW'($past(cnt_q) + 1'b1)));

   // R4
   sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && (cnt_q != '0) && (cnt_q >= thr_i)) |=> $stable(cnt_q));

   // R3
   no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !inc_i) |=> $stable(cnt_q));

   // R8
   clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/dlog_capture.sv
module dlog_capture
   import dlog_pkg::*;
#(
   parameter int unsigned IdxW  = 5,
   parameter int unsigned RoleW = 4,
   parameter int unsigned AddrW = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             take_i,
   input  logic             first_i,
   input  logic             clr_i,
   input  logic [IdxW-1:0]  idx_i,
   input  logic             no_match_i,
   input  logic [1:0]       type_i,
   input  logic [RoleW-1:0] role_i,
   input  logic             role_rd_i,
   input  logic             role_wr_i,
   input  logic [AddrW-1:0] addr_i,
   output logic [IdxW-1:0]  idx_o,
   output logic [RoleW-1:0] role_o,
   output logic [NumAccTypes-1:0] type_o,
   output logic             no_match_o,
   output logic             role_rd_o,
   output logic             role_wr_o,
   output logic [AddrW-1:0] addr_o
);
   logic [NumAccTypes-1:0] type_hot;

   for (genvar g = 0; g < NumAccTypes; g++) begin : g_type_dec
      assign type_hot[g] = (type_i == 2'(g));
   end

   logic [IdxW-1:0]        idx_q;
   logic [RoleW-1:0]       role_q;
   logic [NumAccTypes-1:0] type_q;
   logic                   nm_q, rr_q, rw_q;
   logic [AddrW-1:0]       addr_q;
   logic                   load;

   assign load = take_i && first_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q  <= '0;
         role_q <= '0;
         type_q <= '0;
         nm_q   <= 1'b0;
         rr_q   <= 1'b0;
         rw_q   <= 1'b0;
         addr_q <= '0;
      end else if (clr_i) begin
         idx_q  <= '0;
         role_q <= '0;
         type_q <= '0;
         nm_q   <= 1'b0;
         rr_q   <= 1'b0;
         rw_q   <= 1'b0;
         addr_q <= '0;
      end else if (load) begin
         idx_q  <= idx_i;
         role_q <= role_i;
         type_q <= type_hot;
         nm_q   <= no_match_i;
         rr_q   <= role_rd_i;
         rw_q   <= role_wr_i;
         addr_q <= addr_i;
      end
   end

   assign idx_o      = idx_q;
   assign role_o     = role_q;
   assign type_o     = type_q;
   assign no_match_o = nm_q;
   assign role_rd_o  = rr_q;
   assign role_wr_o  = rw_q;
   assign addr_o     = addr_q;

   // R6
   freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !first_i) |=> ($stable(addr_q) && $stable(idx_q) && $stable(type_q)
                                && $stable(role_q)));

   // R7
   addr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && first_i && !clr_i) |=> (addr_q == $past(addr_i)));

   // R6
   type_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(type_q));
endmodule

// File: rtl/dlog_top.sv
module dlog_top
   import dlog_pkg::*;
#(
   parameter int unsigned CntW  = 8,
   parameter int unsigned IdxW  = 5,
   parameter int unsigned RoleW = 4,
   parameter int unsigned AddrW = 32,
   parameter int unsigned RegW  = 32,
   localparam int unsigned CfgW = CntW + 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_we_i,
   input  logic [CfgW-1:0]  cfg_wdata_i,
   input  logic             evt_valid_i,
   input  logic [IdxW-1:0]  evt_idx_i,
   input  logic             evt_no_match_i,
   input  logic [1:0]       evt_type_i,
   input  logic [RoleW-1:0] evt_role_i,
   input  logic             evt_role_rd_deny_i,
   input  logic             evt_role_wr_deny_i,
   input  logic             evt_log_en_i,
   input  logic [AddrW-1:0] evt_addr_i,
   input  logic             intr_ack_i,
   output logic [RegW-1:0]  cfg_o,
   output logic [RegW-1:0]  status_o,
   output logic [AddrW-1:0] addr_o,
   output logic             intr_o
);
   localparam int unsigned OffType = CntW;
   localparam int unsigned OffNm   = OffType + NumAccTypes;
   localparam int unsigned OffRr   = OffNm + 1;
   localparam int unsigned OffRw   = OffRr + 1;
   localparam int unsigned OffRole = OffRw + 1;
   localparam int unsigned OffIdx  = OffRole + RoleW;
   localparam int unsigned StatW   = OffIdx + IdxW;

   if (StatW > RegW) begin : g_bad_stat
      $error("status fields do not fit the register width");
   end
   if (CfgW > RegW) begin : g_bad_cfg
      $error("config fields do not fit the register width");
   end
   if (CntW < 1 || IdxW < 1 || RoleW < 1 || AddrW < 1) begin : g_bad_w
      $error("all field widths must be at least one bit");
   end

   logic            en, cfg_clr, clr, counted, empty;
   logic [CntW-1:0] thr, cnt;
   logic [IdxW-1:0] l_idx;
   logic [RoleW-1:0] l_role;
   logic [NumAccTypes-1:0] l_type;
   logic            l_nm, l_rr, l_rw;

   dlog_cfg_reg #(.CntW(CntW)) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .wdata_i (cfg_wdata_i),
      .en_o    (en),
      .thr_o   (thr),
      .clr_o   (cfg_clr)
   );

   assign clr     = cfg_clr | intr_ack_i;
   assign counted = evt_valid_i & en & evt_log_en_i;

   dlog_counter #(.CntW(CntW)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (counted),
      .clr_i   (clr),
      .thr_i   (thr),
      .cnt_o   (cnt),
      .empty_o (empty),
      .irq_o   (intr_o)
   );

   dlog_capture #(.IdxW(IdxW), .RoleW(RoleW), .AddrW(AddrW)) u_cap (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .take_i     (counted),
      .first_i    (empty),
      .clr_i      (clr),
      .idx_i      (evt_idx_i),
      .no_match_i (evt_no_match_i),
      .type_i     (evt_type_i),
      .role_i     (evt_role_i),
      .role_rd_i  (evt_role_rd_deny_i),
      .role_wr_i  (evt_role_wr_deny_i),
      .addr_i     (evt_addr_i),
      .idx_o      (l_idx),
      .role_o     (l_role),
      .type_o     (l_type),
      .no_match_o (l_nm),
      .role_rd_o  (l_rr),
      .role_wr_o  (l_rw),
      .addr_o     (addr_o)
   );

   assign status_o[CntW-1:0]                  = cnt;
   assign status_o[OffNm-1:OffType]           = l_type;
   assign status_o[OffNm]                     = l_nm;
   assign status_o[OffRr]                     = l_rr;
   assign status_o[OffRw]                     = l_rw;
   assign status_o[OffIdx-1:OffRole]          = l_role;
   assign status_o[StatW-1:OffIdx]            = l_idx;
   if (StatW < RegW) begin : g_stat_pad
      assign status_o[RegW-1:StatW] = '0;
   end

   assign cfg_o[0]        = en;
   assign cfg_o[1]        = 1'b0;
   assign cfg_o[CfgW-1:2] = thr;
   if (CfgW < RegW) begin : g_cfg_pad
      assign cfg_o[RegW-1:CfgW] = '0;
   end

   // R5
   irq_needs_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      intr_o |-> (status_o[CntW-1:0] != '0));

   // R9
   ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      intr_ack_i |=> ((status_o == '0) && (addr_o == '0) && !intr_o));
endmodule

// File: tb/tb_dlog_top.sv
`timescale 1ns/100ps
module tb_dlog_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [9:0]  cfg_wdata = '0;
   logic        ev = 1'b0;
   logic [4:0]  ev_idx = '0;
   logic        ev_nm = 1'b0;
   logic [1:0]  ev_type = '0;
   logic [3:0]  ev_role = '0;
   logic        ev_rr = 1'b0, ev_rw = 1'b0, ev_le = 1'b0;
   logic [31:0] ev_addr = '0;
   logic        ack = 1'b0;
   logic [31:0] cfg_w, st_w, ad_w;
   logic        irq;

   always #2.5 clk = ~clk;

   dlog_top dut (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
      .evt_valid_i(ev), .evt_idx_i(ev_idx), .evt_no_match_i(ev_nm), .evt_type_i(ev_type),
      .evt_role_i(ev_role), .evt_role_rd_deny_i(ev_rr), .evt_role_wr_deny_i(ev_rw),
      .evt_log_en_i(ev_le), .evt_addr_i(ev_addr), .intr_ack_i(ack),
      .cfg_o(cfg_w), .status_o(st_w), .addr_o(ad_w), .intr_o(irq)
   );

   typedef struct {
      logic [31:0] cfg;
      logic [31:0] st;
      logic [31:0] ad;
      logic        irq;
      string       tag;
   } exp_t;
   exp_t q[$];
   exp_t e;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference model state
   bit        m_en = 0;
   bit [7:0]  m_thr = 0, m_cnt = 0;
   bit [22:8] m_rec = 0;
   bit [31:0] m_addr = 0;

   task automatic step(input string tag);
      bit clr, counted, lim;
      exp_t x;
      clr = (cfg_we && cfg_wdata[1]) || ack;
      counted = ev && m_en && ev_le;
      if (clr) begin
         m_cnt = 0; m_rec = 0; m_addr = 0;
      end else if (counted) begin
         if (m_cnt == 0) begin
            m_rec = '0;
            m_rec[8]  = (ev_type == 2'd0);
            m_rec[9]  = (ev_type == 2'd1);
            m_rec[10] = (ev_type == 2'd2);
            m_rec[11] = ev_nm;
            m_rec[12] = ev_rr;
            m_rec[13] = ev_rw;
            m_rec[17:14] = ev_role;
            m_rec[22:18] = ev_idx;
            m_addr = ev_addr;
         end
         lim = ((m_cnt != 0) && (m_cnt >= m_thr)) || (m_cnt == 8'hFF);
         if (!lim) m_cnt = m_cnt + 1;
      end
      if (cfg_we) begin
         m_en = cfg_wdata[0];
         m_thr = cfg_wdata[9:2];
      end
      x.cfg = {22'd0, m_thr, 1'b0, m_en};
      x.st  = {9'd0, m_rec, m_cnt};
      x.ad  = m_addr;
      x.irq = (m_cnt != 0) && (m_cnt >= m_thr);
      x.tag = tag;
      q.push_back(x);
      @(negedge clk);
      cfg_we = 0; ev = 0; ack = 0;
   endtask

   task automatic do_cfg(input bit en, input bit clr, input bit [7:0] thr, input string tag);
      cfg_we = 1; cfg_wdata = {thr, clr, en};
      step(tag);
   endtask

   task automatic do_ev(input bit [4:0] idx, input bit nm, input bit [1:0] typ,
                        input bit [3:0] role, input bit rr, input bit rw, input bit le,
                        input bit [31:0] addr, input string tag);
      ev = 1; ev_idx = idx; ev_nm = nm; ev_type = typ; ev_role = role;
      ev_rr = rr; ev_rw = rw; ev_le = le; ev_addr = addr;
      step(tag);
   endtask

   task automatic do_ack(input string tag);
      ack = 1;
      step(tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         e = q.pop_front();
         checks++;
         if (cfg_w !== e.cfg || st_w !== e.st || ad_w !== e.ad || irq !== e.irq) begin
            fails++;
            $display("FAIL %s: act cfg=%h st=%h addr=%h irq=%b exp cfg=%h st=%h addr=%h irq=%b",
                     e.tag, cfg_w, st_w, ad_w, irq, e.cfg, e.st, e.ad, e.irq);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (cfg_w !== 0 || st_w !== 0 || ad_w !== 0 || irq !== 0) begin
         fails++;
         $display("FAIL R1 in reset: act cfg=%h st=%h addr=%h irq=%b exp all zero",
                  cfg_w, st_w, ad_w, irq);
      end
      rst_n = 1;
      @(negedge clk);
      step("R1 idle after reset");
      do_ev(5'd3, 0, 2'd0, 4'd1, 0, 0, 1, 32'h1111_0000, "R3 event with logging off");
      do_cfg(1, 0, 8'd3, "R2 enable with threshold 3");
      do_ev(5'd4, 0, 2'd1, 4'd2, 0, 0, 0, 32'h2222_0000, "R3 range log flag clear");
      do_ev(5'd7, 0, 2'd0, 4'd5, 0, 0, 1, 32'hDEAD_BEE4, "R6 R7 first read denial");
      do_ev(5'd2, 1, 2'd1, 4'd9, 1, 1, 1, 32'h0000_0100, "R6 second denial no overwrite");
      do_ev(5'd1, 0, 2'd2, 4'd3, 0, 0, 1, 32'h0000_0200, "R5 count reaches threshold");
      do_ev(5'd1, 0, 2'd2, 4'd3, 0, 0, 1, 32'h0000_0300, "R4 hold at threshold");
      do_ack("R9 acknowledge clears");
      do_cfg(1, 0, 8'd0, "R5 threshold zero count zero no irq");
      do_ev(5'd31, 1, 2'd2, 4'd15, 1, 0, 1, 32'hFFFF_FFFC, "R4 R5 threshold zero first denial");
      do_ev(5'd8, 0, 2'd0, 4'd0, 0, 0, 1, 32'h1234_5678, "R4 threshold zero holds at one");
      cfg_we = 1; cfg_wdata = {8'd2, 1'b1, 1'b1};
      ev = 1; ev_idx = 5'd6; ev_type = 2'd1; ev_le = 1; ev_addr = 32'hAAAA_0000;
      step("R8 clear wins over same-cycle event");
      do_ev(5'd12, 0, 2'd3, 4'd6, 0, 1, 1, 32'h5555_0008, "R6 type code 3 and role write flag");
      do_ev(5'd9, 0, 2'd1, 4'd4, 0, 0, 1, 32'h6666_0000, "R5 irq at threshold 2");
      ack = 1; ev = 1; ev_le = 1; ev_idx = 5'd1; ev_addr = 32'h7777_0000;
      step("R9 ack wins over same-cycle event");
      do_cfg(1, 0, 8'd255, "R2 threshold 255");
      for (int i = 0; i < 258; i++)
         do_ev(5'(i), 0, 2'(i % 3), 4'(i), 0, 0, 1, 32'(i * 4), "R4 saturate at 255");
      do_cfg(0, 0, 8'd255, "R2 disable logging");
      do_ev(5'd0, 0, 2'd0, 4'd0, 0, 0, 1, 32'h9, "R3 disabled event ignored");
      do_cfg(0, 1, 8'd10, "R8 clear strobe via config");
      step("R2 strobe bit reads zero");
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: act hung exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule